// File: doc/BRIEF.md
# GPIO Edge Detect Controller

A bank of general-purpose pins, 21 by default, behind a small synchronous register bus. Each pin input first passes through a two-stage synchronizer. The controller then compares the synchronized level with its value one clock earlier.

Two per-pin enable registers choose which transitions count: one for low-to-high and one for high-to-low. Setting both enables either direction. A matching transition sets a sticky edge-status bit, which software clears by writing a one to it.

Any set status bit raises `irq`. The status bits that are also set in a wake-select register raise `wake`, which a power sequencer can use to leave a sleep state. The same block drives the pins: a direction register gives the output enables, and write-one-to-set and write-one-to-clear registers change the output latch.

Top module: `gpio_edge_ctrl`

Register offsets (byte addresses). Each register uses bits N-1:0 and reads zeros above them:

- 0x00 LEVEL: synchronized pin level, read-only.
- 0x04 DIR: direction, 1 means output.
- 0x08 OUT_SET: write 1 to set an output bit; reads the output latch.
- 0x0C OUT_CLR: write 1 to clear an output bit; reads the output latch.
- 0x10 RISE_EN: low-to-high enable per pin.
- 0x14 FALL_EN: high-to-low enable per pin.
- 0x18 EDGE_STAT: sticky status, write 1 to clear.
- 0x1C WAKE_SEL: selects the status bits that drive `wake`.

## Requirements
- R1: After reset every register reads zero, and `irq`, `wake`, `pin_out` and `pin_oe` are all zero.
- R2: With only the RISE_EN bit set, a 0-to-1 change on that pin sets its EDGE_STAT bit. The bit is set no later than the third rising clock edge after the change. A 1-to-0 change on the same pin does not set the bit.
- R3: With only the FALL_EN bit set, a 1-to-0 change on that pin sets its EDGE_STAT bit within three clocks. A 0-to-1 change does not set the bit.
- R4: With both enables set, either direction sets the bit. With neither enable set, no change on that pin ever sets it.
- R5: Writing 1 to an EDGE_STAT bit clears it, and writing 0 leaves it unchanged. If a detected edge and a clear reach the same bit on the same clock, the bit stays set.
- R6: `irq` is high exactly while at least one EDGE_STAT bit is set.
- R7: `wake` is high exactly while some EDGE_STAT bit is set whose WAKE_SEL bit is also 1. `wake` therefore never rises without `irq`.
- R8: A pin level held for two clock periods is always detected. A two-clock pulse sets the status of a pin enabled for rising edges and also of a pin enabled for falling edges.
- R9: A write of 1 to an OUT_SET bit drives that `pin_out` bit high, and a write of 1 to an OUT_CLR bit drives it low. Zero bits leave the latch unchanged. When set and clear writes to the same bit follow one another, the later write decides the value.
- R10: `pin_oe` equals DIR and changes only on a write to DIR.
- R11: Writes to bits at position N and above are ignored and those bits read 0. Unmapped addresses read 0.
- R12: LEVEL reads the pin input two clocks after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe, one write per clock |
| rdata | output | 32 | Read data for `addr`, combinational |
| pin_in | input | N | Asynchronous pin inputs |
| pin_out | output | N | Output latch |
| pin_oe | output | N | Output enables (direction) |
| irq | output | 1 | OR of all status bits |
| wake | output | 1 | OR of status bits selected by WAKE_SEL |

## Verification
The bench drives single rising and falling transitions on pins configured as rise-only, fall-only, both and neither. This shows whether each enable gates its own direction and only that one. A two-clock pulse applied to a rise-only pin and a fall-only pin at the same time tests the minimum detectable width on both edges. A falling edge timed to land on the same clock as a status clear checks the set-over-clear priority. Back-to-back set and clear writes in both orders tell last-write ordering apart from any fixed priority between the two registers.

// File: rtl/gpio_edge_pkg.sv
// Package gpio_edge_pkg
// Shared constants for the GPIO edge controller: bus address width and the
// byte offsets of each register. All registers are word aligned.
package gpio_edge_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_LEVEL = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_DIR   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_SET   = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_CLR   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_RISE  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_FALL  = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_WAKE  = 8'h1C;
endpackage

// File: rtl/gpio_sync.sv
// Module gpio_sync
// Multi-stage synchronizer for N asynchronous pin inputs.
// Assumes: STAGES >= 1. Reset loads zero into every stage, so a pin
// held low through reset produces no edge afterwards.
module gpio_sync #(
    parameter int N      = 21,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture the raw pins
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d;
                end
            end else begin : g_next
                // Later stages: shift down the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_detect.sv
// Module gpio_edge_detect
// Compares the synchronized level with its previous value and sets sticky
// status bits for the enabled transition directions.
// Assumes: level is already synchronous to clk. A clear and a new edge on
// the same bit in the same cycle leave the bit set.
module gpio_edge_detect #(
    parameter int N = 21
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level,
    input  logic [N-1:0] rise_en,
    input  logic [N-1:0] fall_en,
    input  logic [N-1:0] clr,
    output logic [N-1:0] status_q
);
    logic [N-1:0] prev_q;
    logic [N-1:0] rise_hit;
    logic [N-1:0] fall_hit;

    // Hold the level from the previous clock
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    // Find enabled transitions
    always_comb begin
        rise_hit = level & ~prev_q & rise_en;
        fall_hit = ~level & prev_q & fall_en;
    end

    // Sticky status: clear first, then apply new hits so a hit wins
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr) | rise_hit | fall_hit;
    end
endmodule

// File: rtl/gpio_regs.sv
// Module gpio_regs
// Register file and read multiplexer for the GPIO edge controller.
// Assumes: DW > N. Bits at position N and above are not stored and read as
// zero. One write per clock, so set and clear writes apply in arrival order.
module gpio_regs
    import gpio_edge_pkg::*;
#(
    parameter int N  = 21,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wbits,
    input  logic              we,
    output logic [DW-1:0]     rdata,
    input  logic [N-1:0]      level,
    input  logic [N-1:0]      status,
    output logic [N-1:0]      dir_q,
    output logic [N-1:0]      out_q,
    output logic [N-1:0]      rise_en_q,
    output logic [N-1:0]      fall_en_q,
    output logic [N-1:0]      wake_sel_q,
    output logic [N-1:0]      status_clr
);
    localparam int PAD = DW - N;

    logic wr_dir, wr_set, wr_clr, wr_rise, wr_fall, wr_stat, wr_wake;
    logic [N-1:0] rd_bits;

    // Decode write strobes
    always_comb begin
        wr_dir  = we && (addr == OFF_DIR);
        wr_set  = we && (addr == OFF_SET);
        wr_clr  = we && (addr == OFF_CLR);
        wr_rise = we && (addr == OFF_RISE);
        wr_fall = we && (addr == OFF_FALL);
        wr_stat = we && (addr == OFF_STAT);
        wr_wake = we && (addr == OFF_WAKE);
    end

    // Status clear mask for the edge detector
    assign status_clr = wr_stat ? wbits : '0;

    // Plain read/write configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q      <= '0;
            rise_en_q  <= '0;
            fall_en_q  <= '0;
            wake_sel_q <= '0;
        end else begin
            if (wr_dir)  dir_q      <= wbits;
            if (wr_rise) rise_en_q  <= wbits;
            if (wr_fall) fall_en_q  <= wbits;
            if (wr_wake) wake_sel_q <= wbits;
        end
    end

    // Output latch: write-one-to-set and write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= '0;
        else if (wr_set) out_q <= out_q | wbits;
        else if (wr_clr) out_q <= out_q & ~wbits;
    end

    // Read multiplexer
    always_comb begin
        case (addr)
            OFF_LEVEL: rd_bits = level;
            OFF_DIR:   rd_bits = dir_q;
            OFF_SET:   rd_bits = out_q;
            OFF_CLR:   rd_bits = out_q;
            OFF_RISE:  rd_bits = rise_en_q;
            OFF_FALL:  rd_bits = fall_en_q;
            OFF_STAT:  rd_bits = status;
            OFF_WAKE:  rd_bits = wake_sel_q;
            default:   rd_bits = '0;
        endcase
    end

    assign rdata = {{PAD{1'b0}}, rd_bits};
endmodule

// File: rtl/gpio_edge_ctrl.sv
// Module gpio_edge_ctrl
// Top level of the GPIO edge controller. It synchronizes the pins, detects
// enabled edges into sticky status, holds the pin output registers and
// forms the interrupt and wake requests.
// Assumes: synchronous active-low reset, and a single register write per clock.
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int N           = 21,
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              we,
    output logic [DW-1:0]     rdata,
    input  logic [N-1:0]      pin_in,
    output logic [N-1:0]      pin_out,
    output logic [N-1:0]      pin_oe,
    output logic              irq,
    output logic              wake
);
    logic [N-1:0] level_s;
    logic [N-1:0] status_q;
    logic [N-1:0] status_clr;
    logic [N-1:0] dir_q, out_q, rise_en_q, fall_en_q, wake_sel_q;
    logic         unused_wdata_hi;

    // Upper write bits are reserved and have no storage
    assign unused_wdata_hi = ^wdata[DW-1:N];

    gpio_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (level_s)
    );

    gpio_edge_detect #(.N(N)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (level_s),
        .rise_en  (rise_en_q),
        .fall_en  (fall_en_q),
        .clr      (status_clr),
        .status_q (status_q)
    );

    gpio_regs #(.N(N), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .wbits      (wdata[N-1:0]),
        .we         (we),
        .rdata      (rdata),
        .level      (level_s),
        .status     (status_q),
        .dir_q      (dir_q),
        .out_q      (out_q),
        .rise_en_q  (rise_en_q),
        .fall_en_q  (fall_en_q),
        .wake_sel_q (wake_sel_q),
        .status_clr (status_clr)
    );

    // Pin drive and request outputs
    always_comb begin
        pin_out = out_q;
        pin_oe  = dir_q;
        irq     = |status_q;
        wake    = |(status_q & wake_sel_q);
    end
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
// Module gpio_edge_ctrl_chk
// Property checker bound into gpio_edge_ctrl. It watches the bus, the pin
// outputs, the requests and the internal status and enable state.
module gpio_edge_ctrl_chk
    import gpio_edge_pkg::*;
#(
    parameter int N  = 21,
    parameter int DW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DW-1:0]     wdata,
    input logic              we,
    input logic [N-1:0]      pin_out,
    input logic [N-1:0]      pin_oe,
    input logic              irq,
    input logic              wake,
    input logic [N-1:0]      status,
    input logic [N-1:0]      rise_en,
    input logic [N-1:0]      fall_en
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq && !wake && pin_out == '0 && pin_oe == '0));

    // R7
    wake_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> irq);

    // R4
    status_only_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((status & ~$past(status) & ~($past(rise_en) | $past(fall_en))) == '0));

    // R5
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == OFF_STAT) |=> ((status & $past(status)) == $past(status)));

    // R9
    out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFF_SET) |=> ((pin_out & $past(wdata[N-1:0])) == $past(wdata[N-1:0])));

    // R9
    out_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFF_CLR) |=> ((pin_out & $past(wdata[N-1:0])) == '0));

    // R10
    dir_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == OFF_DIR) |=> $stable(pin_oe));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.N(N), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wdata   (wdata),
    .we      (we),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .irq     (irq),
    .wake    (wake),
    .status  (status_q),
    .rise_en (rise_en_q),
    .fall_en (fall_en_q)
);

// File: tb/tb_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_edge_ctrl;
    localparam int N  = 21;
    localparam int DW = 32;
    localparam logic [31:0] MASK = 32'h001F_FFFF;

    localparam logic [7:0] A_LEVEL = 8'h00, A_DIR = 8'h04, A_SET = 8'h08,
                           A_CLR = 8'h0C, A_RISE = 8'h10, A_FALL = 8'h14,
                           A_STAT = 8'h18, A_WAKE = 8'h1C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          we = 1'b0;
    logic [DW-1:0] rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out, pin_oe;
    logic          irq, wake;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    gpio_edge_ctrl #(.N(N), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq(irq), .wake(wake)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Write one register; returns at the falling edge after the write.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    // Drive pins at a falling edge and wait past the three-clock latency.
    task automatic drive_settle(input logic [N-1:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(A_DIR, d);  check("R1 dir", d, 0);
        rd(A_SET, d);  check("R1 out", d, 0);
        rd(A_RISE, d); check("R1 rise", d, 0);
        rd(A_FALL, d); check("R1 fall", d, 0);
        rd(A_STAT, d); check("R1 stat", d, 0);
        rd(A_WAKE, d); check("R1 wake_sel", d, 0);
        check("R1 outputs", {pin_out, pin_oe, irq, wake} == '0, 1);
    endtask

    task automatic t_rise;
        logic [31:0] d;
        wr(A_RISE, 32'h1);
        drive_settle(21'h1);
        rd(A_STAT, d); check("R2 rise sets", d, 32'h1);
        wr(A_STAT, 32'h1);
        drive_settle(21'h0);
        rd(A_STAT, d); check("R2 fall ignored", d, 0);
        wr(A_RISE, 0);
    endtask

    task automatic t_fall;
        logic [31:0] d;
        wr(A_FALL, 32'h2);
        drive_settle(21'h2);
        rd(A_STAT, d); check("R3 rise ignored", d, 0);
        drive_settle(21'h0);
        rd(A_STAT, d); check("R3 fall sets", d, 32'h2);
        wr(A_STAT, 32'h2);
        wr(A_FALL, 0);
    endtask

    task automatic t_both_none;
        logic [31:0] d;
        wr(A_RISE, 32'h4); wr(A_FALL, 32'h4);
        drive_settle(21'h4);
        rd(A_STAT, d); check("R4 both rise", d, 32'h4);
        wr(A_STAT, 32'h4);
        drive_settle(21'h0);
        rd(A_STAT, d); check("R4 both fall", d, 32'h4);
        wr(A_STAT, 32'h4);
        wr(A_RISE, 0); wr(A_FALL, 0);
        drive_settle(21'h8);
        drive_settle(21'h0);
        rd(A_STAT, d); check("R4 none enabled", d, 0);
    endtask

    task automatic t_short_pulse;
        logic [31:0] d;
        wr(A_RISE, 32'h10); wr(A_FALL, 32'h20);
        @(negedge clk); pin_in = 21'h30;
        repeat (2) @(negedge clk);
        pin_in = 21'h0;
        drive_settle(21'h0);
        rd(A_STAT, d); check("R8 two-clock pulse", d, 32'h30);
        wr(A_STAT, 32'h30);
        wr(A_RISE, 0); wr(A_FALL, 0);
    endtask

    task automatic t_w1c;
        logic [31:0] d;
        wr(A_RISE, 32'h5); wr(A_FALL, 32'h4);
        drive_settle(21'h5);
        wr(A_STAT, 32'h0);
        rd(A_STAT, d); check("R5 write zero keeps", d, 32'h5);
        wr(A_STAT, 32'h1);
        rd(A_STAT, d); check("R5 w1c", d, 32'h4);
        // Falling edge of pin 2 lands on the same clock as the clear
        @(negedge clk); pin_in = 21'h1;
        @(posedge clk); @(negedge clk); @(posedge clk);
        @(negedge clk); addr = A_STAT; wdata = 32'h4; we = 1'b1;
        @(negedge clk); we = 1'b0;
        rd(A_STAT, d); check("R5 set wins over clear", d, 32'h4);
        wr(A_STAT, 32'h4);
        rd(A_STAT, d); check("R5 clear alone", d, 0);
        drive_settle(21'h0);
        wr(A_RISE, 0); wr(A_FALL, 0);
    endtask

    task automatic t_irq_wake;
        wr(A_WAKE, 32'h40); wr(A_RISE, 32'hC0);
        check("R6 irq idle", irq, 0);
        drive_settle(21'h80);
        check("R6 irq on status", irq, 1);
        check("R7 wake unselected", wake, 0);
        drive_settle(21'hC0);
        check("R7 wake selected", wake, 1);
        wr(A_STAT, 32'h40);
        check("R7 wake drops", wake, 0);
        wr(A_STAT, 32'h80);
        check("R6 irq drops", irq, 0);
        wr(A_RISE, 0);
        drive_settle(21'h0);
    endtask

    task automatic t_outputs;
        logic [31:0] d;
        wr(A_DIR, 32'hF);
        check("R10 oe", pin_oe, 21'hF);
        wr(A_SET, 32'h5);
        check("R9 set", pin_out, 21'h5);
        wr(A_SET, 32'h0);
        check("R9 set zero", pin_out, 21'h5);
        wr(A_CLR, 32'h1);
        check("R9 clear", pin_out, 21'h4);
        wr(A_SET, 32'h2); wr(A_CLR, 32'h2);
        check("R9 clear after set", pin_out, 21'h4);
        wr(A_CLR, 32'h8); wr(A_SET, 32'h8);
        check("R9 set after clear", pin_out, 21'hC);
        rd(A_CLR, d); check("R9 readback", d, 32'hC);
        wr(A_STAT, 32'h1);
        check("R10 oe unchanged", pin_oe, 21'hF);
    endtask

    task automatic t_reserved;
        logic [31:0] d;
        wr(A_WAKE, 32'hFFFF_FFFF);
        rd(A_WAKE, d); check("R11 reserved bits", d, MASK);
        wr(A_WAKE, 0);
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, d); check("R11 unmapped", d, 0);
    endtask

    task automatic t_level;
        logic [31:0] d;
        @(negedge clk); pin_in = 21'h12345;
        @(posedge clk);
        @(negedge clk);
        rd(A_LEVEL, d); check("R12 not yet", d, 0);
        @(posedge clk); @(negedge clk);
        rd(A_LEVEL, d); check("R12 level", d, 32'h12345);
        pin_in = '0;
    endtask

    initial begin
        #500_000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rise();
        t_fall();
        t_both_none();
        t_short_pulse();
        t_w1c();
        t_irq_wake();
        t_outputs();
        t_reserved();
        t_level();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule